// File: doc/BRIEF.md
# Remote Terminal Command Decoder

This block sits behind the word decoder of a remote terminal on a dual-redundant serial avionics bus. Each time a command word has been received and validated, a one-cycle strobe presents it. The block then decides whether the command is meant for this terminal. It does so by comparing the command's address field with a strapped five-bit terminal address, which is guarded by its own parity pin, and by recognising the broadcast address.

For every command the terminal accepts, the block latches several things until the next accepted command:

- the transmit/receive direction;
- the five-bit count field;
- whether the command is a mode command;
- the number of data words the message carries.

At the same strobe it samples the subsystem flag pins into a ready-to-send status word. A reply-enable output tells the transmit side whether a status word may go out at all. Broadcast commands, a command the subsystem has flagged as illegal, and a corrupt address strap all hold the reply off. Manchester coding, the transceivers and the movement of data words are handled elsewhere.

Top module: `rt_cmd_decoder`

## Requirements
- R1: While rst_n is low, and on the first cycle after reset, strap_fault, mode_cmd, tr_bit and reply_en are 0. In that same state, wc_field, word_total and status_word are all zero, and bcast_n is 1.
- R2: The strap address is valid when strap_addr together with strap_par holds an odd number of ones. strap_fault is registered every clock and is 1 exactly when the previous cycle's straps had even parity. No command is accepted while the straps are invalid.
- R3: A strobed command is accepted when the straps are valid and its address (bits 15..11) equals strap_addr or is 31. Latched outputs change only on an accepted strobe, in the cycle after it, and keep their value through non-accepted strobes and idle cycles.
- R4: bcast_n is 0 when the last accepted command carried address 31, and 1 otherwise.
- R5: mode_cmd is 1 when the last accepted command has subaddress bits 9..5 equal to 0 or 31. In that case wc_field holds the mode code number.
- R6: tr_bit shows bit 10 of the last accepted command and wc_field shows its bits 4..0.
- R7: word_total is the message's data word count: wc_field for a non-mode command, 32 when that field is 0, and 0 for a mode command.
- R8: reply_en is re-evaluated on every strobe. It is 1 only when the command is accepted, is not broadcast, and ill_cmd is low in the strobe cycle. Between strobes it holds its value.
- R9: status_word is sampled at an accepted strobe, with this layout: bits 15..11 = strap_addr; bit 10 = ill_cmd; bit 8 = svc_req; bit 3 = ss_busy; bit 2 = ss_flag; bit 0 = ss_err. All other bits are 0 except bit 1, which R10 covers.
- R10: status_word bit 1 equals dyn_bus_acc only when the accepted command is a mode command and ill_cmd is low; otherwise bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_word | input | 16 | Validated received command word |
| cmd_stb | input | 1 | One-cycle strobe marking cmd_word valid |
| strap_addr | input | 5 | Strapped terminal address |
| strap_par | input | 1 | Odd-parity bit for strap_addr |
| ill_cmd | input | 1 | Subsystem marks the strobed command illegal |
| ss_busy | input | 1 | Subsystem busy flag |
| ss_flag | input | 1 | Subsystem flag |
| svc_req | input | 1 | Service request flag |
| ss_err | input | 1 | Subsystem error flag |
| dyn_bus_acc | input | 1 | Dynamic bus control acceptance |
| strap_fault | output | 1 | Strap parity error |
| bcast_n | output | 1 | Active-low broadcast command latched |
| mode_cmd | output | 1 | Latched command is a mode command |
| tr_bit | output | 1 | Latched transmit/receive bit |
| wc_field | output | 5 | Latched count / mode code field |
| word_total | output | 6 | Data words in the message |
| reply_en | output | 1 | Status reply allowed |
| status_word | output | 16 | Assembled status word |

## Verification
The bench builds the decoder with its default widths: a 5-bit address, a 5-bit subaddress and a 5-bit count in a 16-bit word. These defaults make the broadcast address and both mode subaddresses easy to reach with biased random commands. The zero count that means a 32-word message comes up often, and so do strap parity flips in between commands. A behavioural model predicts every output on every cycle, across directed cases followed by a long biased random run.

// File: rtl/rtcd_pkg.sv
package rtcd_pkg;
    // status word bit positions (fixed by the bus standard's reply layout)
    localparam int unsigned ST_MSG_ERR  = 10;
    localparam int unsigned ST_SVC_REQ  = 8;
    localparam int unsigned ST_BUSY     = 3;
    localparam int unsigned ST_SS_FLAG  = 2;
    localparam int unsigned ST_DYN_BUS  = 1;
    localparam int unsigned ST_TERM_ERR = 0;
endpackage

// File: rtl/rtcd_strap_check.sv
module rtcd_strap_check #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              strap_par,
    output logic              strap_ok
);
    always_comb begin
        strap_ok = ^{strap_addr, strap_par};
    end
endmodule

// File: rtl/rtcd_field_split.sv
module rtcd_field_split #(
    parameter int ADDR_W = 5,
    parameter int SUB_W  = 5,
    parameter int WC_W   = 5
) (
    input  logic [ADDR_W+SUB_W+WC_W:0] cmd_word,
    output logic [ADDR_W-1:0]          addr,
    output logic                       tr,
    output logic [WC_W-1:0]            wc,
    output logic                       is_bcast,
    output logic                       is_mode
);
    localparam int WORD_W = ADDR_W + 1 + SUB_W + WC_W;
    localparam int TR_POS = SUB_W + WC_W;

    logic [SUB_W-1:0] sub;

    always_comb begin
        addr     = cmd_word[WORD_W-1 -: ADDR_W];
        tr       = cmd_word[TR_POS];
        sub      = cmd_word[TR_POS-1 -: SUB_W];
        wc       = cmd_word[WC_W-1:0];
        is_bcast = &addr;
        is_mode  = (sub == '0) || (&sub);
    end
endmodule

// File: rtl/rt_cmd_decoder.sv
module rt_cmd_decoder #(
    parameter int ADDR_W = 5,
    parameter int SUB_W  = 5,
    parameter int WC_W   = 5,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              cmd_stb,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              strap_par,
    input  logic              ill_cmd,
    input  logic              ss_busy,
    input  logic              ss_flag,
    input  logic              svc_req,
    input  logic              ss_err,
    input  logic              dyn_bus_acc,
    output logic              strap_fault,
    output logic              bcast_n,
    output logic              mode_cmd,
    output logic              tr_bit,
    output logic [WC_W-1:0]   wc_field,
    output logic [WC_W:0]     word_total,
    output logic              reply_en,
    output logic [WORD_W-1:0] status_word
);
    import rtcd_pkg::*;

    localparam logic [WC_W:0] FULL_CNT = {1'b1, {WC_W{1'b0}}};

    typedef struct packed {
        logic              fault;
        logic              bcast;
        logic              mode;
        logic              tr;
        logic [WC_W-1:0]   wc;
        logic [WC_W:0]     total;
        logic              reply;
        logic [WORD_W-1:0] status;
    } dec_state_t;

    dec_state_t st_d, st_q;

    logic              strap_ok;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_tr, cmd_bcast, cmd_mode;
    logic [WC_W-1:0]   cmd_wc;
    logic              accept;

    rtcd_strap_check #(.ADDR_W(ADDR_W)) u_strap (
        .strap_addr (strap_addr),
        .strap_par  (strap_par),
        .strap_ok   (strap_ok)
    );

    rtcd_field_split #(.ADDR_W(ADDR_W), .SUB_W(SUB_W), .WC_W(WC_W)) u_split (
        .cmd_word (cmd_word),
        .addr     (cmd_addr),
        .tr       (cmd_tr),
        .wc       (cmd_wc),
        .is_bcast (cmd_bcast),
        .is_mode  (cmd_mode)
    );

    always_comb begin
        st_d       = st_q;
        st_d.fault = !strap_ok;
        accept     = cmd_stb && strap_ok && (cmd_bcast || (cmd_addr == strap_addr));
        if (cmd_stb) begin
            st_d.reply = accept && !cmd_bcast && !ill_cmd;
        end
        if (accept) begin
            st_d.bcast = cmd_bcast;
            st_d.mode  = cmd_mode;
            st_d.tr    = cmd_tr;
            st_d.wc    = cmd_wc;
            if (cmd_mode) begin
                st_d.total = '0;
            end else if (cmd_wc == '0) begin
                st_d.total = FULL_CNT;
            end else begin
                st_d.total = {1'b0, cmd_wc};
            end
            st_d.status                       = '0;
            st_d.status[WORD_W-1 -: ADDR_W]   = strap_addr;
            st_d.status[ST_MSG_ERR]           = ill_cmd;
            st_d.status[ST_SVC_REQ]           = svc_req;
            st_d.status[ST_BUSY]              = ss_busy;
            st_d.status[ST_SS_FLAG]           = ss_flag;
            st_d.status[ST_DYN_BUS]           = dyn_bus_acc && cmd_mode && !ill_cmd;
            st_d.status[ST_TERM_ERR]          = ss_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strap_fault = st_q.fault;
    assign bcast_n     = !st_q.bcast;
    assign mode_cmd    = st_q.mode;
    assign tr_bit      = st_q.tr;
    assign wc_field    = st_q.wc;
    assign word_total  = st_q.total;
    assign reply_en    = st_q.reply;
    assign status_word = st_q.status;

    // R2
    bad_strap_no_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && !strap_ok) |=> !reply_en);

    // R8
    illegal_no_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && ill_cmd) |=> !reply_en);

    // R4
    bcast_no_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bcast_n |-> !reply_en);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |=> ($stable(wc_field) && $stable(status_word) && $stable(reply_en)));

    // R7
    mode_no_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cmd |-> (word_total == '0));

    // R10
    dyn_bus_mode_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[ST_DYN_BUS] |-> (mode_cmd && !status_word[ST_MSG_ERR]));
endmodule

// File: tb/rt_cmd_decoder_test.sv
module rt_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        cmd_stb = 1'b0;
    logic [4:0]  strap_addr = 5'd9;
    logic        strap_par = 1'b1;
    logic        ill_cmd = 1'b0, ss_busy = 1'b0, ss_flag = 1'b0;
    logic        svc_req = 1'b0, ss_err = 1'b0, dyn_bus_acc = 1'b0;
    logic        strap_fault, bcast_n, mode_cmd, tr_bit, reply_en;
    logic [4:0]  wc_field;
    logic [5:0]  word_total;
    logic [15:0] status_word;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    // model state
    logic        m_fault, m_bcast, m_mode, m_tr, m_reply;
    logic [4:0]  m_wc;
    logic [5:0]  m_total;
    logic [15:0] m_status;

    always #4 clk = ~clk;

    rt_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_stb(cmd_stb),
        .strap_addr(strap_addr), .strap_par(strap_par), .ill_cmd(ill_cmd),
        .ss_busy(ss_busy), .ss_flag(ss_flag), .svc_req(svc_req), .ss_err(ss_err),
        .dyn_bus_acc(dyn_bus_acc), .strap_fault(strap_fault), .bcast_n(bcast_n),
        .mode_cmd(mode_cmd), .tr_bit(tr_bit), .wc_field(wc_field),
        .word_total(word_total), .reply_en(reply_en), .status_word(status_word)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 strap_fault", int'(strap_fault), int'(m_fault));
        chk("R4 bcast_n", int'(bcast_n), int'(!m_bcast));
        chk("R5 mode_cmd", int'(mode_cmd), int'(m_mode));
        chk("R6 tr_bit", int'(tr_bit), int'(m_tr));
        chk("R6 wc_field", int'(wc_field), int'(m_wc));
        chk("R7 word_total", int'(word_total), int'(m_total));
        chk("R8 reply_en", int'(reply_en), int'(m_reply));
        chk("R9/R10 status_word", int'(status_word), int'(m_status));
    endtask

    task automatic model_update();
        int  a, sa, sub, wc;
        bit  ok, acc, bc, md;
        if (!rst_n) begin
            m_fault = 0; m_bcast = 0; m_mode = 0; m_tr = 0; m_reply = 0;
            m_wc = 0; m_total = 0; m_status = 0;
            return;
        end
        sa  = int'(strap_addr);
        ok  = ($countones({strap_addr, strap_par}) % 2) == 1;
        m_fault = !ok;
        a   = int'(cmd_word[15:11]);
        sub = int'(cmd_word[9:5]);
        wc  = int'(cmd_word[4:0]);
        bc  = (a == 31);
        md  = (sub == 0) || (sub == 31);
        acc = cmd_stb && ok && (bc || a == sa);
        if (cmd_stb) m_reply = acc && !bc && !ill_cmd;
        if (acc) begin
            m_bcast = bc; m_mode = md; m_tr = cmd_word[10]; m_wc = wc[4:0];
            m_total = md ? 6'd0 : (wc == 0 ? 6'd32 : 6'(wc));
            m_status = 16'(sa) << 11;
            if (ill_cmd) m_status = m_status | 16'h0400;
            if (svc_req) m_status = m_status | 16'h0100;
            if (ss_busy) m_status = m_status | 16'h0008;
            if (ss_flag) m_status = m_status | 16'h0004;
            if (dyn_bus_acc && md && !ill_cmd) m_status = m_status | 16'h0002;
            if (ss_err)  m_status = m_status | 16'h0001;
        end
    endtask

    // called at a negedge: inputs already set; run one clock and compare
    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [15:0] mk(int a, int tr, int sub, int wc);
        return {a[4:0], tr[0], sub[4:0], wc[4:0]};
    endfunction

    task automatic send(logic [15:0] w, bit ill);
        cmd_word = w; cmd_stb = 1; ill_cmd = ill;
        step();
        cmd_stb = 0; ill_cmd = 0;
        step();
    endtask

    task automatic set_strap(int a, bit good);
        strap_addr = a[4:0];
        strap_par  = good ? ~^a[4:0] : ^a[4:0];
    endtask

    initial begin
        #(8 * 150000);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        step();
        // R1 reset state
        chk("R1 reset reply_en", int'(reply_en), 0);
        chk("R1 reset bcast_n", int'(bcast_n), 1);
        chk("R1 reset status", int'(status_word), 0);
        rst_n = 1;
        step();
        chk("R1 after reset wc_field", int'(wc_field), 0);
        set_strap(9, 1);
        // R3 R6 R7 R9: own address receive, count 5
        ss_busy = 1; svc_req = 1;
        send(mk(9, 0, 3, 5), 0);
        chk("R7 count 5", int'(word_total), 5);
        chk("R8 reply own", int'(reply_en), 1);
        // R7 count 0 means 32
        send(mk(9, 1, 4, 0), 0);
        chk("R7 count 0 -> 32", int'(word_total), 32);
        // R3 other address ignored but reply cleared
        send(mk(12, 0, 2, 7), 0);
        chk("R3 foreign hold wc", int'(wc_field), 0);
        chk("R8 foreign reply", int'(reply_en), 0);
        // R4 broadcast
        send(mk(31, 0, 1, 3), 0);
        chk("R4 bcast_n low", int'(bcast_n), 0);
        chk("R8 bcast no reply", int'(reply_en), 0);
        // R5 R10 mode codes with subaddress 0 and 31
        dyn_bus_acc = 1;
        send(mk(9, 1, 0, 0), 0);
        chk("R10 dba set", int'(status_word[1]), 1);
        send(mk(9, 1, 31, 18), 0);
        chk("R5 mode code", int'(wc_field), 18);
        // R10 non-mode command clears dba bit
        send(mk(9, 1, 7, 2), 0);
        chk("R10 dba clear non-mode", int'(status_word[1]), 0);
        // R8 illegal command
        send(mk(9, 1, 0, 1), 1);
        chk("R8 illegal blocks", int'(reply_en), 0);
        chk("R10 illegal no dba", int'(status_word[1]), 0);
        // R2 bad strap parity
        set_strap(9, 0);
        send(mk(9, 0, 3, 9), 0);
        chk("R2 fault flag", int'(strap_fault), 1);
        chk("R2 not accepted", int'(wc_field), 1);
        set_strap(9, 1);
        step();
        // random run
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom_range(0, 99));
            int a;
            if (r < 45) a = int'(strap_addr);
            else if (r < 65) a = 31;
            else a = int'($urandom_range(0, 31));
            cmd_word    = mk(a, int'($urandom_range(0, 1)),
                             ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) != 0) ? 31 : 0)
                                                         : int'($urandom_range(0, 31)),
                             ($urandom_range(0, 4) == 0) ? 0 : int'($urandom_range(0, 31)));
            cmd_stb     = ($urandom_range(0, 2) != 0);
            ill_cmd     = ($urandom_range(0, 5) == 0);
            ss_busy     = $urandom_range(0, 1) != 0;
            ss_flag     = $urandom_range(0, 1) != 0;
            svc_req     = $urandom_range(0, 1) != 0;
            ss_err      = $urandom_range(0, 1) != 0;
            dyn_bus_acc = $urandom_range(0, 1) != 0;
            if ($urandom_range(0, 40) == 0)
                set_strap(int'($urandom_range(0, 30)), $urandom_range(0, 3) != 0);
            step();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule